// File: doc/BRIEF.md
# Interrupt Controller Command and Register Port

This block is the byte-wide, two-address programming interface of an eight-line priority interrupt controller. Software writes command bytes to address 0 and data bytes to address 1. The block decodes each byte and runs the multi-byte initialisation sequence. It holds the interrupt mask, the vector base, the mode flags, the in-service vector and the rotating priority offset. It also answers register reads and poll reads.

Two things come from neighbouring logic: request capture and the priority scan. The request vector arrives on `irr_in`. The scan supplies two results: the highest-priority in-service line, and the current winning request. The acknowledge path marks lines as in service through `isr_set`. When a poll read or an initialisation must clear a request, the block tells the capture logic through `req_clr` and `init_strobe`.

Top module: `picc_regif`

## Requirements
- R1: After reset, these all read 0: `mask`, `isr`, `prio_ofs`, `vec_base`, `init_phase`, every mode flag, `level_err` and `init_strobe`. A read of address 0 then returns `irr_in`.
- R2: A write to address 0 with bit 4 set starts initialisation. On the next cycle `init_phase` is 1 and `init_strobe` is high for exactly one cycle. The write clears `mask`, `isr`, `prio_ofs`, `vec_base`, every mode flag and the read-select. It also captures four-word from bit 0, single from bit 1 and `level_err` from bit 3.
- R3: In phase 1, an address-1 write loads `vec_base` with the byte ANDed with 0xF8. The next phase is 3 when single and four-word are both set, 0 when only single is set, and 2 otherwise.
- R4: In phase 2, an address-1 write moves to phase 3 if four-word is set, else to phase 0. In phase 3, an address-1 write sets nested mode from bit 4 and auto end-of-interrupt from bit 1, then returns to phase 0.
- R5: In phase 0, an address-1 write loads `mask` with the byte.
- R6: An address-0 write with bit 4 clear and bit 3 set is a control byte:
  - bit 2 arms poll;
  - if bit 1 is set, bit 0 becomes the read-select;
  - if bit 6 is set, bit 5 becomes `spec_mask`.
  A bit 1 or bit 6 that is clear leaves its target unchanged.
- R7: For any other address-0 write, bits 7:5 are a command code. Codes 0 and 4 set `rot_auto_eoi` to bit 7.
- R8: Code 1 clears the in-service bit of `top_isr_line` when `top_isr_vld` is high. Code 5 does the same and also sets `prio_ofs` to that line plus 1, modulo 8. With `top_isr_vld` low, neither code changes anything.
- R9: The remaining codes act as follows:
  - code 3 clears the in-service bit chosen by bits 2:0;
  - code 6 sets `prio_ofs` to bits 2:0 plus 1, modulo 8;
  - code 7 clears the chosen bit and sets `prio_ofs` to that line plus 1;
  - code 2 changes nothing.
- R10: With poll armed, a read returns the line number while `win_vld` is high. In that case `req_clr` is the one-hot bit of that line during the read, and the line's in-service bit is cleared. With no winner the read returns 7 and `req_clr` stays 0. Either read disarms poll.
- R11: A read that is not a poll read returns `isr` at address 0 when read-select is 1, `irr_in` at address 0 otherwise, and `mask` at address 1.
- R12: Bits high on `isr_set` are ORed into `isr` on the next cycle, unless an initialisation write occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 1 | Register address (0 command, 1 data) |
| wdata | input | 8 | Write byte |
| irr_in | input | 8 | Request vector from capture logic |
| isr_set | input | 8 | Lines to mark in service (acknowledge) |
| top_isr_vld | input | 1 | An in-service line exists |
| top_isr_line | input | 3 | Highest-priority in-service line |
| win_vld | input | 1 | A request wins the scan |
| win_line | input | 3 | Winning request line |
| rdata | output | 8 | Read byte |
| mask | output | 8 | Interrupt mask |
| isr | output | 8 | In-service vector |
| prio_ofs | output | 3 | Line with highest priority |
| vec_base | output | 8 | Vector base (low three bits zero) |
| init_phase | output | 2 | Initialisation phase 0..3 |
| four_word | output | 1 | Mode byte expected |
| single_mode | output | 1 | No cascade byte |
| nested_mode | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| rot_auto_eoi | output | 1 | Rotate on automatic end of interrupt |
| spec_mask | output | 1 | Special mask mode |
| level_err | output | 1 | Unsupported level mode requested |
| init_strobe | output | 1 | One-cycle pulse after initialisation start (drop CPU interrupt) |
| req_clr | output | 8 | One-hot request clear during poll read |

## Verification
On every cycle, the assertions check the following:
- the state that follows an initialisation start;
- the vector-base load and phase exit from phase 1;
- the mask load in phase 0;
- that a specific end-of-interrupt clears its line;
- that a request clear only occurs during a read and matches the returned line;
- that poll is disarmed after a poll read.

Only the bench scenarios show the rest:
- the full phase walk in the single, single-with-mode-byte and cascaded variants;
- the rotation offsets of each command code;
- the no-effect cases of code 2, of enable bits that are clear, and of an end-of-interrupt with nothing in service;
- the read multiplexing.

// File: rtl/picc_pkg.sv
package picc_pkg;
  localparam int LINES = 8;
  localparam int LW    = $clog2(LINES);
  localparam int DW    = 8;
  localparam logic [DW-1:0] BASE_KEEP = 8'hF8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BASE = 2'd1,
    PH_CASC = 2'd2,
    PH_MODE = 2'd3
  } ph_e;

  typedef enum logic [2:0] {
    OP_ROT_CLR    = 3'd0,
    OP_NS_EOI     = 3'd1,
    OP_NOP        = 3'd2,
    OP_SP_EOI     = 3'd3,
    OP_ROT_SET    = 3'd4,
    OP_ROT_NS_EOI = 3'd5,
    OP_SET_PRIO   = 3'd6,
    OP_ROT_SP_EOI = 3'd7
  } op_e;

  function automatic ph_e after_base(input logic single, input logic four);
    if (single) return four ? PH_MODE : PH_IDLE;
    return PH_CASC;
  endfunction

  function automatic ph_e after_casc(input logic four);
    return four ? PH_MODE : PH_IDLE;
  endfunction

  function automatic logic [LINES-1:0] line_bit(input logic [LW-1:0] l);
    return {{(LINES-1){1'b0}}, 1'b1} << l;
  endfunction

  function automatic logic [LW-1:0] next_line(input logic [LW-1:0] l);
    return l + 1'b1;
  endfunction
endpackage

// File: rtl/picc_cfg.sv
module picc_cfg
  import picc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_wr,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output ph_e           phase,
  output logic          four_word,
  output logic          single_mode,
  output logic          nested_mode,
  output logic          auto_eoi,
  output logic          level_err,
  output logic [DW-1:0] vec_base,
  output logic [LINES-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      four_word   <= 1'b0;
      single_mode <= 1'b0;
      nested_mode <= 1'b0;
      auto_eoi    <= 1'b0;
      level_err   <= 1'b0;
      vec_base    <= '0;
      mask        <= '0;
    end else if (init_wr) begin
      phase       <= PH_BASE;
      four_word   <= wdata[0];
      single_mode <= wdata[1];
      level_err   <= wdata[3];
      nested_mode <= 1'b0;
      auto_eoi    <= 1'b0;
      vec_base    <= '0;
      mask        <= '0;
    end else if (data_wr) begin
      unique case (phase)
        PH_IDLE: mask <= wdata[LINES-1:0];
        PH_BASE: begin
          vec_base <= wdata & BASE_KEEP;
          phase    <= after_base(single_mode, four_word);
        end
        PH_CASC: phase <= after_casc(four_word);
        PH_MODE: begin
          nested_mode <= wdata[4];
          auto_eoi    <= wdata[1];
          phase       <= PH_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/picc_svc.sv
module picc_svc
  import picc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_wr,
  input  logic             ocw2_wr,
  input  op_e              op,
  input  logic [LW-1:0]    op_line,
  input  logic             op_bit,
  input  logic [LINES-1:0] isr_set,
  input  logic             top_isr_vld,
  input  logic [LW-1:0]    top_isr_line,
  input  logic             poll_hit,
  input  logic [LW-1:0]    poll_line,
  output logic [LINES-1:0] isr,
  output logic [LW-1:0]    prio_ofs,
  output logic             rot_auto_eoi
);
  logic [LINES-1:0] clr;
  logic [LW-1:0]    ofs_n;
  logic             rot_n;

  always_comb begin
    clr   = '0;
    ofs_n = prio_ofs;
    rot_n = rot_auto_eoi;
    if (ocw2_wr) begin
      unique case (op)
        OP_ROT_CLR, OP_ROT_SET: rot_n = op_bit;
        OP_NS_EOI: if (top_isr_vld) clr = line_bit(top_isr_line);
        OP_ROT_NS_EOI: if (top_isr_vld) begin
          clr   = line_bit(top_isr_line);
          ofs_n = next_line(top_isr_line);
        end
        OP_SP_EOI: clr = line_bit(op_line);
        OP_SET_PRIO: ofs_n = next_line(op_line);
        OP_ROT_SP_EOI: begin
          clr   = line_bit(op_line);
          ofs_n = next_line(op_line);
        end
        OP_NOP: ;
      endcase
    end
    if (poll_hit) clr = clr | line_bit(poll_line);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || init_wr) begin
      isr          <= '0;
      prio_ofs     <= '0;
      rot_auto_eoi <= 1'b0;
    end else begin
      isr          <= (isr & ~clr) | isr_set;
      prio_ofs     <= ofs_n;
      rot_auto_eoi <= rot_n;
    end
  end
endmodule

// File: rtl/picc_rdport.sv
module picc_rdport
  import picc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_wr,
  input  logic             ocw3_wr,
  input  logic [4:0]       ctl_bits,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [LINES-1:0] irr_in,
  input  logic [LINES-1:0] isr,
  input  logic [LINES-1:0] mask,
  input  logic             win_vld,
  input  logic [LW-1:0]    win_line,
  output logic [DW-1:0]    rdata,
  output logic             spec_mask,
  output logic             poll_armed,
  output logic             poll_rd,
  output logic             poll_hit,
  output logic [LINES-1:0] req_clr
);
  // ctl_bits = {sm_en, sm_val, poll, rs_en, rs_val}
  logic rd_sel;

  assign poll_rd  = rd_en && poll_armed;
  assign poll_hit = poll_rd && win_vld;
  assign req_clr  = poll_hit ? line_bit(win_line) : '0;

  always_comb begin
    if (poll_armed)
      rdata = win_vld ? DW'(win_line) : DW'(LINES - 1);
    else if (addr)
      rdata = DW'(mask);
    else
      rdata = DW'(rd_sel ? isr : irr_in);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || init_wr) begin
      poll_armed <= 1'b0;
      rd_sel     <= 1'b0;
      spec_mask  <= 1'b0;
    end else begin
      if (poll_rd) poll_armed <= 1'b0;
      if (ocw3_wr) begin
        if (ctl_bits[2]) poll_armed <= 1'b1;
        if (ctl_bits[1]) rd_sel     <= ctl_bits[0];
        if (ctl_bits[4]) spec_mask  <= ctl_bits[3];
      end
    end
  end
endmodule

// File: rtl/picc_regif.sv
module picc_regif
  import picc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  input  logic [7:0] irr_in,
  input  logic [7:0] isr_set,
  input  logic       top_isr_vld,
  input  logic [2:0] top_isr_line,
  input  logic       win_vld,
  input  logic [2:0] win_line,
  output logic [7:0] rdata,
  output logic [7:0] mask,
  output logic [7:0] isr,
  output logic [2:0] prio_ofs,
  output logic [7:0] vec_base,
  output logic [1:0] init_phase,
  output logic       four_word,
  output logic       single_mode,
  output logic       nested_mode,
  output logic       auto_eoi,
  output logic       rot_auto_eoi,
  output logic       spec_mask,
  output logic       level_err,
  output logic       init_strobe,
  output logic [7:0] req_clr
);
  // named events for the checker
  logic cmd_wr, init_wr, ocw3_wr, ocw2_wr, data_wr;
  logic poll_armed, poll_rd, poll_hit;
  ph_e  phase;

  assign cmd_wr  = wr_en && !addr;
  assign init_wr = cmd_wr && wdata[4];
  assign ocw3_wr = cmd_wr && !wdata[4] && wdata[3];
  assign ocw2_wr = cmd_wr && !wdata[4] && !wdata[3];
  assign data_wr = wr_en && addr;
  assign init_phase = phase;

  always_ff @(posedge clk) begin
    if (!rst_n) init_strobe <= 1'b0;
    else        init_strobe <= init_wr;
  end

  picc_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .init_wr(init_wr), .data_wr(data_wr),
    .wdata(wdata), .phase(phase), .four_word(four_word),
    .single_mode(single_mode), .nested_mode(nested_mode),
    .auto_eoi(auto_eoi), .level_err(level_err), .vec_base(vec_base),
    .mask(mask)
  );

  picc_svc u_svc (
    .clk(clk), .rst_n(rst_n), .init_wr(init_wr), .ocw2_wr(ocw2_wr),
    .op(op_e'(wdata[7:5])), .op_line(wdata[2:0]), .op_bit(wdata[7]),
    .isr_set(isr_set), .top_isr_vld(top_isr_vld),
    .top_isr_line(top_isr_line), .poll_hit(poll_hit), .poll_line(win_line),
    .isr(isr), .prio_ofs(prio_ofs), .rot_auto_eoi(rot_auto_eoi)
  );

  picc_rdport u_rd (
    .clk(clk), .rst_n(rst_n), .init_wr(init_wr), .ocw3_wr(ocw3_wr),
    .ctl_bits({wdata[6:5], wdata[2:0]}), .rd_en(rd_en), .addr(addr),
    .irr_in(irr_in), .isr(isr), .mask(mask), .win_vld(win_vld),
    .win_line(win_line), .rdata(rdata), .spec_mask(spec_mask),
    .poll_armed(poll_armed), .poll_rd(poll_rd), .poll_hit(poll_hit),
    .req_clr(req_clr)
  );
endmodule

// File: rtl/picc_chk.sv
module picc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_wr,
  input logic       data_wr,
  input logic       ocw2_wr,
  input logic       ocw3_wr,
  input logic       rd_en,
  input logic       poll_rd,
  input logic       poll_armed,
  input logic [7:0] wdata,
  input logic [7:0] isr_set,
  input logic [1:0] init_phase,
  input logic [7:0] mask,
  input logic [7:0] isr,
  input logic [2:0] prio_ofs,
  input logic [7:0] vec_base,
  input logic       init_strobe,
  input logic [7:0] rdata,
  input logic [2:0] win_line,
  input logic [7:0] req_clr
);
  // R2
  init_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> (init_phase == 2'd1 && mask == 8'h00 && prio_ofs == 3'd0
                 && vec_base == 8'h00 && init_strobe));

  // R3
  base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !init_wr && init_phase == 2'd1)
      |=> (vec_base == ($past(wdata) & 8'hF8) && init_phase != 2'd1));

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !init_wr && init_phase == 2'd0) |=> mask == $past(wdata));

  // R9
  spec_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ocw2_wr && wdata[7:5] == 3'd3 && isr_set == 8'h00)
      |=> !isr[$past(wdata[2:0])]);

  // R10
  req_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_clr != 8'h00) |-> (rd_en && $countones(req_clr) == 1
                            && rdata == {5'b0, win_line}));

  // R10
  poll_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rd && !ocw3_wr) |=> !poll_armed);
endmodule

bind picc_regif picc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init_wr(init_wr), .data_wr(data_wr),
  .ocw2_wr(ocw2_wr), .ocw3_wr(ocw3_wr), .rd_en(rd_en), .poll_rd(poll_rd),
  .poll_armed(poll_armed), .wdata(wdata), .isr_set(isr_set),
  .init_phase(init_phase), .mask(mask), .isr(isr), .prio_ofs(prio_ofs),
  .vec_base(vec_base), .init_strobe(init_strobe), .rdata(rdata),
  .win_line(win_line), .req_clr(req_clr)
);

// File: tb/test_picc_regif.sv
`timescale 1ns/1ps
module test_picc_regif;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, irr_in = 8'h5A, isr_set = '0;
  logic       top_isr_vld = 1'b0, win_vld = 1'b0;
  logic [2:0] top_isr_line = '0, win_line = '0;
  logic [7:0] rdata, mask, isr, vec_base, req_clr;
  logic [2:0] prio_ofs;
  logic [1:0] init_phase;
  logic four_word, single_mode, nested_mode, auto_eoi, rot_auto_eoi;
  logic spec_mask, level_err, init_strobe;

  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  picc_regif i_picc_regif (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d, output logic [7:0] clr);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #2 d = rdata; clr = req_clr;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic mark(input logic [7:0] v);
    @(negedge clk); isr_set = v;
    @(negedge clk); isr_set = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d, c;
    chk("R1 mask", mask, 0);        chk("R1 isr", isr, 0);
    chk("R1 ofs", prio_ofs, 0);     chk("R1 base", vec_base, 0);
    chk("R1 phase", init_phase, 0);
    chk("R1 flags", {four_word, single_mode, nested_mode, auto_eoi,
                     rot_auto_eoi, spec_mask, level_err, init_strobe}, 0);
    rd(1'b0, d, c);
    chk("R1 R11 irr read", d, 8'h5A);
  endtask

  task automatic t_init_cascade;
    logic [7:0] d, c;
    wr(1'b0, 8'h11);
    chk("R2 phase", init_phase, 1);  chk("R2 strobe", init_strobe, 1);
    chk("R2 four/single", {four_word, single_mode}, 2'b10);
    @(negedge clk);
    chk("R2 strobe width", init_strobe, 0);
    wr(1'b1, 8'h4F);
    chk("R3 base", vec_base, 8'h48); chk("R3 casc next", init_phase, 2);
    wr(1'b1, 8'h04);
    chk("R4 casc to mode", init_phase, 3);
    wr(1'b1, 8'h12);
    chk("R4 mode bits", {nested_mode, auto_eoi}, 2'b11);
    chk("R4 mode to idle", init_phase, 0);
    wr(1'b1, 8'hA5);
    chk("R5 mask", mask, 8'hA5);
    rd(1'b1, d, c);
    chk("R11 mask read", d, 8'hA5);
  endtask

  task automatic t_init_single;
    wr(1'b1, 8'h33);
    wr(1'b0, 8'h1A);
    chk("R2 mask cleared", mask, 0);    chk("R2 level err", level_err, 1);
    chk("R2 single", single_mode, 1);   chk("R2 base cleared", vec_base, 0);
    chk("R2 mode cleared", {nested_mode, auto_eoi}, 0);
    wr(1'b1, 8'h27);
    chk("R3 base single", vec_base, 8'h20); chk("R3 single next", init_phase, 0);
    wr(1'b0, 8'h13);
    chk("R2 level clear", level_err, 0);
    wr(1'b1, 8'h08);
    chk("R3 single four next", init_phase, 3);
    wr(1'b1, 8'h00);
    chk("R4 mode clear", {nested_mode, auto_eoi, init_phase}, 0);
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h00);
    chk("R3 casc no four", init_phase, 2);
    wr(1'b1, 8'h00);
    chk("R4 casc to idle", init_phase, 0);
  endtask

  task automatic t_eoi;
    mark(8'h8C);
    chk("R12 set", isr, 8'h8C);
    top_isr_vld = 1'b1; top_isr_line = 3'd2;
    wr(1'b0, 8'h20);
    chk("R8 ns eoi", isr, 8'h88);  chk("R8 ofs kept", prio_ofs, 0);
    top_isr_line = 3'd3;
    wr(1'b0, 8'hA0);
    chk("R8 rot ns eoi", isr, 8'h80); chk("R8 rot ofs", prio_ofs, 4);
    wr(1'b0, 8'h67);
    chk("R9 sp eoi", isr, 8'h00);
    wr(1'b0, 8'hC5);
    chk("R9 set prio", prio_ofs, 6);
    wr(1'b0, 8'hC7);
    chk("R9 set prio wrap", prio_ofs, 0);
    mark(8'h02);
    wr(1'b0, 8'hE1);
    chk("R9 rot sp isr", isr, 0);  chk("R9 rot sp ofs", prio_ofs, 2);
    mark(8'h10);
    wr(1'b0, 8'h44);
    chk("R9 nop isr", isr, 8'h10); chk("R9 nop ofs", prio_ofs, 2);
    top_isr_vld = 1'b0;
    wr(1'b0, 8'hA0);
    chk("R8 none isr", isr, 8'h10); chk("R8 none ofs", prio_ofs, 2);
    wr(1'b0, 8'h80);
    chk("R7 rot set", rot_auto_eoi, 1);
    wr(1'b0, 8'h00);
    chk("R7 rot clear", rot_auto_eoi, 0);
  endtask

  task automatic t_poll;
    logic [7:0] d, c;
    mark(8'h20);
    win_vld = 1'b1; win_line = 3'd5;
    wr(1'b0, 8'h0C);
    rd(1'b0, d, c);
    chk("R10 poll line", d, 5);  chk("R10 req clr", c, 8'h20);
    chk("R10 isr cleared", isr, 8'h10);
    rd(1'b0, d, c);
    chk("R10 disarmed", d, 8'h5A); chk("R10 no clr", c, 0);
    win_vld = 1'b0;
    wr(1'b0, 8'h0C);
    rd(1'b1, d, c);
    chk("R10 none", d, 7);  chk("R10 none clr", c, 0);
    chk("R10 none isr", isr, 8'h10);
  endtask

  task automatic t_ocw3;
    logic [7:0] d, c;
    wr(1'b0, 8'h0B);
    rd(1'b0, d, c);
    chk("R6 R11 isr sel", d, 8'h10);
    wr(1'b0, 8'h08);
    rd(1'b0, d, c);
    chk("R6 sel kept", d, 8'h10);
    wr(1'b0, 8'h0A);
    rd(1'b0, d, c);
    chk("R6 R11 irr sel", d, 8'h5A);
    wr(1'b0, 8'h68);
    chk("R6 smask set", spec_mask, 1);
    wr(1'b0, 8'h28);
    chk("R6 smask kept", spec_mask, 1);
    wr(1'b0, 8'h48);
    chk("R6 smask clear", spec_mask, 0);
    wr(1'b0, 8'h10);
    chk("R2 isr cleared", isr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_cascade();
    t_init_single();
    t_eoi();
    t_poll();
    t_ocw3();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule